// File: doc/BRIEF.md
# Attribute-Steered Data Cache Controller

This block is a small direct-mapped data cache that sits between a word-wide load/store requester and external memory. Each access carries a three-bit attribute field that selects its handling. The field decides whether the access may be cached and whether a store may be posted. For cacheable accesses it also decides whether stores go through to memory at once or stay in the line until the line leaves the cache, and whether a store miss brings a line in. A global enable input stands for the address translation unit. While it is low, every access is handled as uncached and unbuffered, whatever its attribute.

A line holds eight 32-bit words (32 bytes). The block moves whole lines over the memory port as eight-beat bursts and moves single words for uncached and write-through traffic. A separate clean command takes a line index. If that line is valid and dirty, the line is written to memory and stays resident. Otherwise the command finishes at once.

The requester holds `cpuReq` and the access fields until `cpuReady` pulses. The clean requester holds `cleanReq` until `cleanDone` pulses. On the memory side, the block holds a beat's fields until `memReady` is high at a clock edge.

Top module: `attr_dcache`

## Requirements
- R1: While `mapEnable` is 0, every access is uncached and unbuffered for any `cpuAttr`: each load is a single-beat memory read, even when repeated, and a store does not complete until memory accepts it.
- R2: The attribute field is `cpuAttr[2]` = extend, `cpuAttr[1]` = cacheable, `cpuAttr[0]` = bufferable. Every line refill is an eight-beat read burst with `memBurst` high. It runs from the line base up to base+28, one 4-byte step per beat.
- R3: With `cpuAttr` = 3'b000, loads and stores go to memory as single beats. `cpuReady` is never given before memory has accepted the beat.
- R4: With cacheable 0 and bufferable 1 (extend ignored), a store is posted: `cpuReady` comes 2 cycles after acceptance even while memory stalls. The next access is not accepted until the posted write has been accepted by memory.
- R5: With `cpuAttr` = 3'b010 (write-through, read-allocate), a store hit updates the line and writes one word to memory. A store miss writes one word to memory and allocates nothing.
- R6: With `cpuAttr` = 3'b011 (write-back, read-allocate), a store hit updates only the line, with no memory traffic. A store miss writes one word to memory and allocates nothing.
- R7: With extend and cacheable both 1, the access is write-back with read/write-allocate: a store miss refills the line, then merges the store into it with no single-word write.
- R8: A load miss in any cacheable mode refills its line. Later loads to that line complete with no memory traffic and return the cached word, including words written by earlier store hits.
- R9: Replacing a dirty line first writes the victim as an eight-beat write burst at the victim's own address. The refill burst starts only after that.
- R10: A clean of a valid dirty line writes it as an eight-beat burst and then pulses `cleanDone`. The line stays valid. A second clean of the same line finishes with no memory traffic.
- R11: A clean of a clean or invalid line pulses `cleanDone` one cycle after acceptance, with no memory traffic. Only write-back stores make a line dirty.
- R12: While `memReq` is high and `memReady` is low, `memReq`, `memWe`, `memBurst`, `memAddr` and `memWData` keep their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mapEnable | input | 1 | Global enable; 0 forces uncached, unbuffered handling |
| cpuReq | input | 1 | Access request, held until `cpuReady` |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuAttr | input | 3 | Attribute field {extend, cacheable, bufferable} |
| cpuAddr | input | 32 | Byte address (word aligned) |
| cpuWData | input | 32 | Store data |
| cpuReady | output | 1 | One-cycle pulse when the access is done |
| cpuRData | output | 32 | Load data, valid with `cpuReady` |
| cleanReq | input | 1 | Clean command, held until `cleanDone` |
| cleanIdx | input | 3 | Line index to clean |
| cleanDone | output | 1 | One-cycle pulse when the clean is done |
| memReq | output | 1 | Memory beat request |
| memWe | output | 1 | 1 = write beat, 0 = read beat |
| memBurst | output | 1 | Beat belongs to an eight-beat line transfer |
| memAddr | output | 32 | Beat byte address |
| memWData | output | 32 | Write beat data |
| memReady | input | 1 | Memory accepts the beat at this edge |
| memRData | input | 32 | Read beat data, valid with `memReady` |

## Verification
Some checks run on every cycle. They confirm that memory beat fields hold steady while stalled, that bursts start at word 0 and step word by word, and that bursts occur only for cacheable traffic or a clean. They also confirm that only write-back stores set a dirty bit, that a strictly ordered access is never reported done before memory has taken it, and that a clean of a non-dirty line finishes in one cycle. Other behaviours can only be shown by directed scenarios with an independent memory model. These are the allocation choice for each attribute encoding, the victim write-back order and data, posted-store completion during a memory stall, and lines staying valid after a clean.

// File: rtl/attr_dcache_pkg.sv
package attr_dcache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DECIDE, ST_EVICT, ST_FILL, ST_MEMRD, ST_MEMWR, ST_DONE
  } ctrlState_t;

  typedef enum logic [1:0] {
    SRC_REQ, SRC_VICTIM, SRC_FILL, SRC_POST
  } memSrc_t;

  typedef struct packed {
    logic cacheable;
    logic bufferable;
    logic writeBack;
    logic allocOnWrite;
  } accMode_t;

  typedef struct packed {
    logic    latchReq;
    logic    latchClean;
    logic    cacheWrWord;
    logic    fillWrWord;
    logic    fillFinish;
    logic    setDirty;
    logic    clearDirty;
    logic    capMem;
    logic    capCache;
    logic    loadPost;
    logic    clearPost;
    logic    beatClr;
    logic    beatInc;
    memSrc_t memSrc;
  } ctrlStrobe_t;

  typedef struct packed {
    logic     hit;
    logic     victimDirty;
    logic     cleanDirty;
    logic     lastBeat;
    logic     postPending;
    logic     reqWe;
    accMode_t mode;
  } dpStatus_t;

  // attr = {extend, cacheable, bufferable}
  function automatic accMode_t decodeAttr(input logic enable, input logic [2:0] attr);
    accMode_t m;
    m = '0;
    if (enable) begin
      if (attr[1]) begin
        m.cacheable    = 1'b1;
        m.bufferable   = 1'b1;
        m.writeBack    = attr[2] | attr[0];
        m.allocOnWrite = attr[2];
      end else begin
        m.bufferable = attr[0];
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/attr_dcache_dp.sv
module attr_dcache_dp
  import attr_dcache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINES      = 8,
  parameter int LINE_WORDS = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobe_t               strobe,
  output dpStatus_t                 status,
  input  logic                      mapEnable,
  input  logic                      cpuWe,
  input  logic [2:0]                cpuAttr,
  input  logic [ADDR_W-1:0]         cpuAddr,
  input  logic [WORD_W-1:0]         cpuWData,
  input  logic [$clog2(LINES)-1:0]  cleanIdx,
  input  logic [WORD_W-1:0]         memRData,
  output logic [ADDR_W-1:0]         memAddr,
  output logic [WORD_W-1:0]         memWData,
  output logic [WORD_W-1:0]         cpuRData
);

  localparam int BYTE_OFF   = $clog2(WORD_W / 8);
  localparam int WORD_OFF_W = $clog2(LINE_WORDS);
  localparam int IDX_W      = $clog2(LINES);
  localparam int IDX_LSB    = BYTE_OFF + WORD_OFF_W;
  localparam int TAG_LSB    = IDX_LSB + IDX_W;
  localparam int TAG_W      = ADDR_W - TAG_LSB;

  logic [ADDR_W-1:0]     reqAddr;
  logic [WORD_W-1:0]     reqData;
  logic                  reqWe;
  accMode_t              reqMode;
  logic [WORD_OFF_W-1:0] beat;
  logic                  postValid;
  logic [ADDR_W-1:0]     postAddr;
  logic [WORD_W-1:0]     postData;
  logic [LINES-1:0]      validBits;
  logic [LINES-1:0]      dirtyBits;
  logic [TAG_W-1:0]      tagMem  [LINES];
  logic [WORD_W-1:0]     dataMem [LINES][LINE_WORDS];
  logic [WORD_W-1:0]     rdataReg;

  logic [IDX_W-1:0]      reqIdx;
  logic [WORD_OFF_W-1:0] reqWord;
  logic [TAG_W-1:0]      reqTag;

  assign reqIdx  = reqAddr[IDX_LSB +: IDX_W];
  assign reqWord = reqAddr[BYTE_OFF +: WORD_OFF_W];
  assign reqTag  = reqAddr[TAG_LSB +: TAG_W];

  // request capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAddr <= '0;
      reqData <= '0;
      reqWe   <= 1'b0;
      reqMode <= '0;
    end else if (strobe.latchReq) begin
      reqAddr <= cpuAddr;
      reqData <= cpuWData;
      reqWe   <= cpuWe;
      reqMode <= decodeAttr(mapEnable, cpuAttr);
    end else if (strobe.latchClean) begin
      reqAddr <= {{TAG_W{1'b0}}, cleanIdx, {IDX_LSB{1'b0}}};
      reqWe   <= 1'b0;
      reqMode <= '0;
    end
  end

  // burst beat counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               beat <= '0;
    else if (strobe.beatClr) beat <= '0;
    else if (strobe.beatInc) beat <= beat + 1'b1;
  end

  // posted single-word write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      postValid <= 1'b0;
      postAddr  <= '0;
      postData  <= '0;
    end else if (strobe.loadPost) begin
      postValid <= 1'b1;
      postAddr  <= reqAddr;
      postData  <= reqData;
    end else if (strobe.clearPost) begin
      postValid <= 1'b0;
    end
  end

  // line state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validBits <= '0;
      dirtyBits <= '0;
      for (int i = 0; i < LINES; i++) tagMem[i] <= '0;
    end else begin
      if (strobe.fillFinish) begin
        validBits[reqIdx] <= 1'b1;
        dirtyBits[reqIdx] <= 1'b0;
        tagMem[reqIdx]    <= reqTag;
      end else if (strobe.setDirty) begin
        dirtyBits[reqIdx] <= 1'b1;
      end else if (strobe.clearDirty) begin
        dirtyBits[reqIdx] <= 1'b0;
      end
    end
  end

  // line data
  always_ff @(posedge clk) begin
    if (strobe.cacheWrWord)     dataMem[reqIdx][reqWord] <= reqData;
    else if (strobe.fillWrWord) dataMem[reqIdx][beat]    <= memRData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rdataReg <= '0;
    else if (strobe.capMem)   rdataReg <= memRData;
    else if (strobe.capCache) rdataReg <= dataMem[reqIdx][reqWord];
  end

  always_comb begin
    unique case (strobe.memSrc)
      SRC_VICTIM: begin
        memAddr  = {tagMem[reqIdx], reqIdx, beat, {BYTE_OFF{1'b0}}};
        memWData = dataMem[reqIdx][beat];
      end
      SRC_FILL: begin
        memAddr  = {reqTag, reqIdx, beat, {BYTE_OFF{1'b0}}};
        memWData = '0;
      end
      SRC_POST: begin
        memAddr  = postAddr;
        memWData = postData;
      end
      default: begin
        memAddr  = reqAddr;
        memWData = reqData;
      end
    endcase
  end

  always_comb begin
    status.hit         = validBits[reqIdx] && (tagMem[reqIdx] == reqTag) && reqMode.cacheable;
    status.victimDirty = validBits[reqIdx] && dirtyBits[reqIdx];
    status.cleanDirty  = validBits[cleanIdx] && dirtyBits[cleanIdx];
    status.lastBeat    = (beat == WORD_OFF_W'(LINE_WORDS - 1));
    status.postPending = postValid;
    status.reqWe       = reqWe;
    status.mode        = reqMode;
  end

  assign cpuRData = rdataReg;

  // R11: a dirty bit only ever appears after a write-back store
  assert_dirty_wb_only_R11: assert property (@(posedge clk) disable iff (!rstN)
    (|(dirtyBits & ~$past(dirtyBits))) |-> $past(reqMode.writeBack && reqWe));

endmodule

// File: rtl/attr_dcache_ctrl.sv
module attr_dcache_ctrl
  import attr_dcache_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuReq,
  input  logic        cleanReq,
  input  logic        memReady,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        memReq,
  output logic        memWe,
  output logic        memBurst,
  output logic        cpuReady,
  output logic        cleanDone
);

  ctrlState_t state, nextState;
  logic       opClean;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      opClean <= 1'b0;
    end else begin
      state <= nextState;
      if (strobe.latchClean)    opClean <= 1'b1;
      else if (strobe.latchReq) opClean <= 1'b0;
    end
  end

  always_comb begin
    strobe        = '0;
    strobe.memSrc = SRC_REQ;
    nextState     = state;
    memReq        = 1'b0;
    memWe         = 1'b0;
    memBurst      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (status.postPending) begin
          memReq        = 1'b1;
          memWe         = 1'b1;
          strobe.memSrc = SRC_POST;
          strobe.clearPost = memReady;
        end else if (cleanReq) begin
          strobe.latchClean = 1'b1;
          strobe.beatClr    = 1'b1;
          nextState = status.cleanDirty ? ST_EVICT : ST_DONE;
        end else if (cpuReq) begin
          strobe.latchReq = 1'b1;
          nextState = ST_DECIDE;
        end
      end
      ST_DECIDE: begin
        if (!status.mode.cacheable) begin
          if (status.reqWe && status.mode.bufferable) begin
            strobe.loadPost = 1'b1;
            nextState = ST_DONE;
          end else begin
            nextState = status.reqWe ? ST_MEMWR : ST_MEMRD;
          end
        end else if (status.hit) begin
          if (status.reqWe) begin
            strobe.cacheWrWord = 1'b1;
            strobe.setDirty    = status.mode.writeBack;
            nextState = status.mode.writeBack ? ST_DONE : ST_MEMWR;
          end else begin
            strobe.capCache = 1'b1;
            nextState = ST_DONE;
          end
        end else if (!status.reqWe || status.mode.allocOnWrite) begin
          strobe.beatClr = 1'b1;
          nextState = status.victimDirty ? ST_EVICT : ST_FILL;
        end else begin
          nextState = ST_MEMWR;
        end
      end
      ST_EVICT: begin
        memReq        = 1'b1;
        memWe         = 1'b1;
        memBurst      = 1'b1;
        strobe.memSrc = SRC_VICTIM;
        if (memReady) begin
          strobe.beatInc = 1'b1;
          if (status.lastBeat) begin
            strobe.clearDirty = 1'b1;
            strobe.beatClr    = 1'b1;
            nextState = opClean ? ST_DONE : ST_FILL;
          end
        end
      end
      ST_FILL: begin
        memReq        = 1'b1;
        memBurst      = 1'b1;
        strobe.memSrc = SRC_FILL;
        if (memReady) begin
          strobe.fillWrWord = 1'b1;
          strobe.beatInc    = 1'b1;
          if (status.lastBeat) begin
            strobe.fillFinish = 1'b1;
            nextState = ST_DECIDE;
          end
        end
      end
      ST_MEMRD: begin
        memReq = 1'b1;
        if (memReady) begin
          strobe.capMem = 1'b1;
          nextState = ST_DONE;
        end
      end
      ST_MEMWR: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memReady) nextState = ST_DONE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign cpuReady  = (state == ST_DONE) && !opClean;
  assign cleanDone = (state == ST_DONE) && opClean;

  // R3 (and R1): strictly ordered accesses finish only after memory took the beat
  assert_strict_wait_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReady && !status.mode.cacheable && !status.mode.bufferable) |-> $past(memReady));

  // R1: no line burst for uncached traffic
  assert_uncached_noburst_R1: assert property (@(posedge clk) disable iff (!rstN)
    (memBurst && !opClean) |-> status.mode.cacheable);

  // R11: clean of a non-dirty line is done in the next cycle
  assert_clean_quick_R11: assert property (@(posedge clk) disable iff (!rstN)
    $past(state == ST_IDLE && !status.postPending && cleanReq && !status.cleanDirty)
      |-> cleanDone);

endmodule

// File: rtl/attr_dcache.sv
module attr_dcache
  import attr_dcache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINES      = 8,
  parameter int LINE_WORDS = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     mapEnable,
  input  logic                     cpuReq,
  input  logic                     cpuWe,
  input  logic [2:0]               cpuAttr,
  input  logic [ADDR_W-1:0]        cpuAddr,
  input  logic [WORD_W-1:0]        cpuWData,
  output logic                     cpuReady,
  output logic [WORD_W-1:0]        cpuRData,
  input  logic                     cleanReq,
  input  logic [$clog2(LINES)-1:0] cleanIdx,
  output logic                     cleanDone,
  output logic                     memReq,
  output logic                     memWe,
  output logic                     memBurst,
  output logic [ADDR_W-1:0]        memAddr,
  output logic [WORD_W-1:0]        memWData,
  input  logic                     memReady,
  input  logic [WORD_W-1:0]        memRData
);

  localparam int BYTE_OFF   = $clog2(WORD_W / 8);
  localparam int WORD_OFF_W = $clog2(LINE_WORDS);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  attr_dcache_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cpuReq    (cpuReq),
    .cleanReq  (cleanReq),
    .memReady  (memReady),
    .status    (status),
    .strobe    (strobe),
    .memReq    (memReq),
    .memWe     (memWe),
    .memBurst  (memBurst),
    .cpuReady  (cpuReady),
    .cleanDone (cleanDone)
  );

  attr_dcache_dp #(
    .ADDR_W     (ADDR_W),
    .WORD_W     (WORD_W),
    .LINES      (LINES),
    .LINE_WORDS (LINE_WORDS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .status    (status),
    .mapEnable (mapEnable),
    .cpuWe     (cpuWe),
    .cpuAttr   (cpuAttr),
    .cpuAddr   (cpuAddr),
    .cpuWData  (cpuWData),
    .cleanIdx  (cleanIdx),
    .memRData  (memRData),
    .memAddr   (memAddr),
    .memWData  (memWData),
    .cpuRData  (cpuRData)
  );

  // R12: beat fields hold while memory stalls
  assert_mem_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memWe) && $stable(memBurst)
                               && $stable(memAddr) && $stable(memWData)));

  // R2: a burst starts at word 0 of the line
  assert_burst_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memBurst) |-> (memAddr[BYTE_OFF +: WORD_OFF_W] == '0));

  // R2: burst beats advance one word at a time
  assert_burst_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memBurst && memReady
     && memAddr[BYTE_OFF +: WORD_OFF_W] != WORD_OFF_W'(LINE_WORDS - 1))
      |=> (memBurst && memAddr[BYTE_OFF +: WORD_OFF_W]
           == WORD_OFF_W'($past(memAddr[BYTE_OFF +: WORD_OFF_W]) + 1'b1)));

endmodule

// File: tb/attr_dcache_bench.sv
module attr_dcache_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mapEnable = 1'b1;
  logic        cpuReq = 1'b0;
  logic        cpuWe = 1'b0;
  logic [2:0]  cpuAttr = 3'b000;
  logic [31:0] cpuAddr = '0;
  logic [31:0] cpuWData = '0;
  logic        cpuReady;
  logic [31:0] cpuRData;
  logic        cleanReq = 1'b0;
  logic [2:0]  cleanIdx = '0;
  logic        cleanDone;
  logic        memReq, memWe, memBurst;
  logic [31:0] memAddr, memWData;
  logic        memReady;
  logic [31:0] memRData;
  logic        memOk = 1'b1;

  int checkCount = 0;
  int failCount  = 0;

  always #5 clk = ~clk;

  attr_dcache u_attr_dcache (
    .clk(clk), .rstN(rstN), .mapEnable(mapEnable),
    .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAttr(cpuAttr), .cpuAddr(cpuAddr),
    .cpuWData(cpuWData), .cpuReady(cpuReady), .cpuRData(cpuRData),
    .cleanReq(cleanReq), .cleanIdx(cleanIdx), .cleanDone(cleanDone),
    .memReq(memReq), .memWe(memWe), .memBurst(memBurst), .memAddr(memAddr),
    .memWData(memWData), .memReady(memReady), .memRData(memRData)
  );

  // memory model
  logic [31:0] memModel [0:1023];
  assign memReady = memOk;
  assign memRData = memModel[memAddr[11:2]];

  function automatic logic [31:0] initWord(input logic [31:0] a);
    return 32'hA500_0000 | {22'd0, a[11:2]};
  endfunction

  initial for (int i = 0; i < 1024; i++) memModel[i] = initWord(32'(i * 4));

  always @(posedge clk)
    if (rstN && memReq && memReady && memWe) memModel[memAddr[11:2]] <= memWData;

  // traffic monitor
  int          rdBeats, wrBeats, burstBeats, wrAtFirstRd;
  bit          seenRd;
  logic [31:0] firstBurstAddr, lastBurstAddr;

  always @(posedge clk) begin
    if (rstN && memReq && memReady) begin
      if (memWe) wrBeats++;
      else begin
        if (!seenRd) begin seenRd = 1'b1; wrAtFirstRd = wrBeats; end
        rdBeats++;
      end
      if (memBurst) begin
        if (burstBeats == 0) firstBurstAddr = memAddr;
        lastBurstAddr = memAddr;
        burstBeats++;
      end
    end
  end

  task automatic clearStats();
    rdBeats = 0; wrBeats = 0; burstBeats = 0; wrAtFirstRd = -1; seenRd = 1'b0;
    firstBurstAddr = '0; lastBurstAddr = '0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  endtask

  task automatic cpuStart(input logic we, input logic [2:0] attr,
                          input logic [31:0] addr, input logic [31:0] data);
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAttr = attr; cpuAddr = addr; cpuWData = data;
  endtask

  task automatic cpuWait(output logic [31:0] rdata, output int waitCycles);
    waitCycles = 0;
    do begin
      @(negedge clk);
      waitCycles++;
    end while (!cpuReady);
    rdata  = cpuRData;
    cpuReq = 1'b0;
  endtask

  task automatic cpuDo(input logic we, input logic [2:0] attr, input logic [31:0] addr,
                       input logic [31:0] data, output logic [31:0] rdata,
                       output int waitCycles);
    cpuStart(we, attr, addr, data);
    cpuWait(rdata, waitCycles);
  endtask

  task automatic cleanDo(input logic [2:0] idx, output int waitCycles);
    @(negedge clk);
    cleanReq = 1'b1; cleanIdx = idx;
    waitCycles = 0;
    do begin
      @(negedge clk);
      waitCycles++;
    end while (!cleanDone);
    cleanReq = 1'b0;
  endtask

  task automatic noReadyFor(input int n, input string tag);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (cpuReady) seen++;
    end
    chk(tag, 32'(seen), 32'd0);
  endtask

  // scenarios
  task automatic testReset();
    chk("R12 reset memReq", {31'd0, memReq}, 32'd0);
    chk("R12 reset cpuReady", {31'd0, cpuReady}, 32'd0);
    chk("R11 reset cleanDone", {31'd0, cleanDone}, 32'd0);
  endtask

  task automatic testMapOff();
    logic [31:0] rd; int w;
    mapEnable = 1'b0;
    clearStats();
    cpuDo(1'b0, 3'b011, 32'h040, '0, rd, w);
    chk("R1 load data", rd, initWord(32'h040));
    cpuDo(1'b0, 3'b011, 32'h040, '0, rd, w);
    chk("R1 repeated load reads memory twice", 32'(rdBeats), 32'd2);
    chk("R1 no burst", 32'(burstBeats), 32'd0);
    cpuDo(1'b1, 3'b110, 32'h044, 32'hD000_0000, rd, w);
    chk("R1 store reaches memory", memModel[32'h044 >> 2], 32'hD000_0000);
    chk("R1 single store beat", 32'(wrBeats), 32'd1);
    mapEnable = 1'b1;
  endtask

  task automatic testWriteThrough();
    logic [31:0] rd; int w;
    clearStats();
    cpuDo(1'b0, 3'b010, 32'h048, '0, rd, w);
    chk("R2 refill beats", 32'(burstBeats), 32'd8);
    chk("R2 first burst addr", firstBurstAddr, 32'h040);
    chk("R2 last burst addr", lastBurstAddr, 32'h05C);
    chk("R8 load miss data", rd, initWord(32'h048));
    clearStats();
    cpuDo(1'b0, 3'b010, 32'h05C, '0, rd, w);
    chk("R8 load hit data", rd, initWord(32'h05C));
    chk("R8 load hit no traffic", 32'(rdBeats + wrBeats), 32'd0);
    clearStats();
    cpuDo(1'b1, 3'b010, 32'h048, 32'hD111_1111, rd, w);
    chk("R5 store hit one write", 32'(wrBeats), 32'd1);
    chk("R5 store hit memory", memModel[32'h048 >> 2], 32'hD111_1111);
    cpuDo(1'b0, 3'b010, 32'h048, '0, rd, w);
    chk("R8 load after store hit", rd, 32'hD111_1111);
    chk("R5 store hit no read", 32'(rdBeats), 32'd0);
    cleanDo(3'd2, w);
    chk("R11 clean of write-through line cycles", 32'(w), 32'd1);
    chk("R11 clean of write-through line traffic", 32'(wrBeats), 32'd1);
    clearStats();
    cpuDo(1'b1, 3'b010, 32'h300, 32'hD333_3333, rd, w);
    chk("R5 store miss one write", 32'(wrBeats), 32'd1);
    chk("R5 store miss no refill", 32'(rdBeats), 32'd0);
    cpuDo(1'b0, 3'b010, 32'h300, '0, rd, w);
    chk("R5 no allocation: later load refills", 32'(burstBeats), 32'd8);
    chk("R5 store miss data in memory", rd, 32'hD333_3333);
  endtask

  task automatic testWriteBack();
    logic [31:0] rd; int w;
    clearStats();
    cpuDo(1'b1, 3'b011, 32'h304, 32'hD222_2222, rd, w);
    chk("R6 store hit no traffic", 32'(rdBeats + wrBeats), 32'd0);
    chk("R6 memory untouched", memModel[32'h304 >> 2], initWord(32'h304));
    cpuDo(1'b0, 3'b011, 32'h304, '0, rd, w);
    chk("R6 cached store data", rd, 32'hD222_2222);
    clearStats();
    cpuDo(1'b0, 3'b011, 32'h100, '0, rd, w);
    chk("R9 victim write beats", 32'(wrBeats), 32'd8);
    chk("R9 refill after write-back", 32'(wrAtFirstRd), 32'd8);
    chk("R9 victim address", firstBurstAddr, 32'h300);
    chk("R9 victim data", memModel[32'h304 >> 2], 32'hD222_2222);
    chk("R9 new line data", rd, initWord(32'h100));
    clearStats();
    cpuDo(1'b1, 3'b011, 32'h1A0, 32'hD444_4444, rd, w);
    chk("R6 store miss one write", 32'(wrBeats), 32'd1);
    chk("R6 store miss no refill", 32'(rdBeats), 32'd0);
    cpuDo(1'b0, 3'b011, 32'h1A0, '0, rd, w);
    chk("R6 no allocation: later load refills", 32'(burstBeats), 32'd8);
    chk("R6 store miss data", rd, 32'hD444_4444);
  endtask

  task automatic testWriteAllocate();
    logic [31:0] rd; int w;
    clearStats();
    cpuDo(1'b1, 3'b110, 32'h0C4, 32'hD555_5555, rd, w);
    chk("R7 store miss refills", 32'(rdBeats), 32'd8);
    chk("R7 no single write", 32'(wrBeats), 32'd0);
    chk("R7 memory untouched", memModel[32'h0C4 >> 2], initWord(32'h0C4));
    cpuDo(1'b0, 3'b110, 32'h0C4, '0, rd, w);
    chk("R7 merged data", rd, 32'hD555_5555);
    chk("R7 load hit no traffic", 32'(rdBeats), 32'd8);
    clearStats();
    cleanDo(3'd6, w);
    chk("R10 clean write beats", 32'(wrBeats), 32'd8);
    chk("R10 clean burst addr", firstBurstAddr, 32'h0C0);
    chk("R10 clean data", memModel[32'h0C4 >> 2], 32'hD555_5555);
    clearStats();
    cpuDo(1'b0, 3'b110, 32'h0C4, '0, rd, w);
    chk("R10 line stays valid", 32'(rdBeats + wrBeats), 32'd0);
    chk("R10 data after clean", rd, 32'hD555_5555);
    cleanDo(3'd6, w);
    chk("R10 second clean cycles", 32'(w), 32'd1);
    chk("R10 second clean traffic", 32'(wrBeats), 32'd0);
    cleanDo(3'd7, w);
    chk("R11 invalid line clean cycles", 32'(w), 32'd1);
    chk("R11 invalid line clean traffic", 32'(rdBeats + wrBeats), 32'd0);
  endtask

  task automatic testOrdering();
    logic [31:0] rd; int w;
    clearStats();
    memOk = 1'b0;
    cpuDo(1'b1, 3'b001, 32'h3F0, 32'hD666_6666, rd, w);
    chk("R4 posted store ready cycles", 32'(w), 32'd2);
    chk("R4 no write yet", 32'(wrBeats), 32'd0);
    cpuStart(1'b0, 3'b000, 32'h3F0, '0);
    noReadyFor(5, "R4 next access waits for posted write");
    memOk = 1'b1;
    cpuWait(rd, w);
    chk("R4 load sees posted data", rd, 32'hD666_6666);
    chk("R3 single read beat", 32'(rdBeats), 32'd1);
    clearStats();
    memOk = 1'b0;
    cpuStart(1'b1, 3'b000, 32'h3F4, 32'hD777_7777);
    noReadyFor(6, "R3 store held until memory accepts");
    chk("R12 request held in stall", memAddr, 32'h3F4);
    memOk = 1'b1;
    cpuWait(rd, w);
    chk("R3 store written", memModel[32'h3F4 >> 2], 32'hD777_7777);
    memOk = 1'b0;
    cpuDo(1'b1, 3'b101, 32'h3F8, 32'hD888_8888, rd, w);
    chk("R4 extend bit ignored: posted", 32'(w), 32'd2);
    memOk = 1'b1;
    cpuDo(1'b0, 3'b000, 32'h3F8, '0, rd, w);
    chk("R4 extend-bit store data", rd, 32'hD888_8888);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    finishRun();
  end

  initial begin
    clearStats();
    repeat (4) @(posedge clk);
    @(negedge clk);
    testReset();
    rstN = 1'b1;
    testMapOff();
    testWriteThrough();
    testWriteBack();
    testWriteAllocate();
    testOrdering();
    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule